// File: doc/BRIEF.md
# DMA Transfer Slot Scheduler

This block sits beside one DMA engine and decides what the engine works on next. Software-side logic submits transfers, each one a single pointer to the start of a descriptor chain, into a small ring of slots. Whenever the engine is idle and at least one submitted slot is waiting, the block programs the engine through a register-write port and starts it on the oldest waiting slot. While the engine runs, the block watches two status inputs. One reports that the transfer has finished. The other reports that DMA is still enabled.

A transfer that stays busy too long is aborted by the block. The abort then counts as a completion once the engine reports that it has stopped. Every finished slot is offered on a release handshake, tagged with whether it ended through an abort. Each release returns the slot to the free pool. The free-slot count is an output, so the submitting side can see how much room is left.

Top module: `dma_blit_sched`

## Requirements
- R1: After reset `free_count` is SLOTS-1, `submit_ready` is 1, `rel_valid` is 0 and `done_count` is 0.
- R2: A submission is accepted only while `free_count` is non-zero, and each accepted one lowers `free_count` by one. While `free_count` is zero, `submit_ready` is 0 and a request changes nothing.
- R3: An idle engine with waiting work is started with seven writes on consecutive cycles. The writes are, in order: select 0 (memory address) data 0; select 1 (device address) data 0; select 2 (control) data 0x19; select 3 (mode) data 0x3; select 4 (byte count) data 0; select 5 (descriptor pointer) data the slot's pointer; select 2 (control) data 0x3. Slots start in submission order.
- R4: While running, a high `eng_done` completes the transfer in that cycle. The block writes 0x10 to control (select 2), raises `done_count` by one and offers the slot for release with `rel_aborted` 0.
- R5: If a transfer has not completed TIMEOUT cycles after its start write, the block writes 0x04 to control (abort). It re-arms the deadline so that a further abort write follows TIMEOUT cycles later if there is still no completion.
- R6: After an abort, a low `eng_enable` completes the transfer and the slot is released with `rel_aborted` 1. While `eng_enable` stays high, no completion occurs.
- R7: When idle with nothing waiting, the block writes 0x18 to control exactly once, to turn the engine off. This also happens once after reset.
- R8: Finished slots are offered in completion order, and their index is held while `rel_ready` is low. Each release handshake raises `free_count` by one.
- R9: `eng_done` has no effect while no transfer is running. There is no register write and `done_count` does not change.
- R10: Ring indices wrap at SLOTS, so the slot after index SLOTS-1 is index 0.

Control bit meanings are: bit0 enable, bit1 start, bit2 abort, bit3 descriptor-done, bit4 transfer-done. The mode value 0x3 sets chain mode (bit0) and done-interrupt enable (bit1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| submit_valid | input | 1 | Submission request |
| submit_ptr | input | PTR_W | Descriptor chain start pointer |
| submit_ready | output | 1 | A free slot exists |
| free_count | output | $clog2(SLOTS+1) | Free slots |
| reg_wr_en | output | 1 | Engine register write strobe |
| reg_wr_sel | output | 3 | Engine register select |
| reg_wr_data | output | PTR_W | Engine register write data |
| eng_done | input | 1 | Engine transfer-done status |
| eng_enable | input | 1 | Engine DMA-enable status |
| rel_valid | output | 1 | A finished slot awaits release |
| rel_ready | input | 1 | Release side accepts the slot |
| rel_slot | output | $clog2(SLOTS) | Index of the slot offered |
| rel_aborted | output | 1 | Offered slot ended by abort |
| done_count | output | DONE_W | Completed transfers, wrapping |

## Verification
The bench runs a ring of four slots with a short deadline. It drives three input patterns. The first is single transfers that end through the done flag. The second is a burst that fills the ring until a submission is refused. The third is a transfer the engine never finishes, so the deadline fires, re-arms, and the transfer is finally completed when the enable status drops. The single transfers check the start sequence and the off write. The burst checks that slots start and release in order and that the indices wrap. The stalled transfer checks the exact spacing of the abort writes and that the aborted tag reaches the release side. A done pulse while the engine is idle shows that the status is ignored outside a transfer.

// File: rtl/dbs_pkg.sv
// Shared encodings for the DMA slot scheduler.
// Assumes the engine decodes register selects and control bits as listed here.
package dbs_pkg;
    typedef enum logic [2:0] {
        SEL_MEM_ADDR = 3'd0,
        SEL_DEV_ADDR = 3'd1,
        SEL_CTRL     = 3'd2,
        SEL_MODE     = 3'd3,
        SEL_COUNT    = 3'd4,
        SEL_DESC     = 3'd5
    } eng_reg_e;

    localparam int CTRL_EN    = 0;
    localparam int CTRL_START = 1;
    localparam int CTRL_ABORT = 2;
    localparam int CTRL_DDONE = 3;
    localparam int CTRL_DONE  = 4;

    localparam int MODE_CHAIN = 0;
    localparam int MODE_IRQ   = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRE   = 2'd1,
        ST_ACTIVE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/dbs_ring.sv
// Slot ring: pointer storage, submit/execute/release indices, free and
// pending counts, and the completion counter.
// Assumes push only while free_count != 0, and fire_pop only while work is pending.
module dbs_ring #(
    parameter int SLOTS  = 4,
    parameter int PTR_W  = 32,
    parameter int DONE_W = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW    = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PTR_W-1:0]  push_ptr,
    input  logic              fire_pop,
    input  logic              complete,
    input  logic              complete_aborted,
    input  logic              rel_ready,
    output logic [CW-1:0]     free_count,
    output logic [PTR_W-1:0]  cur_ptr,
    output logic              work_pending,
    output logic              rel_valid,
    output logic [IDX_W-1:0]  rel_slot,
    output logic              rel_aborted,
    output logic [DONE_W-1:0] done_count
);
    localparam logic [CW-1:0]    FREE_INIT = CW'(SLOTS - 1);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(SLOTS - 1);

    logic [IDX_W-1:0] head_q, cur_q, serv_q;
    logic [CW-1:0]    free_q, pend_q;
    logic [DONE_W-1:0] done_q;
    logic [PTR_W-1:0] ptr_all [SLOTS];
    logic [SLOTS-1:0] ab_all;
    logic             pop;

    function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
        return (i == LAST_IDX) ? '0 : i + 1'b1;
    endfunction

    // Per-slot storage of the chain pointer and the aborted tag.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [PTR_W-1:0] ptr_r;
        logic             ab_r;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_r <= '0;
                ab_r  <= 1'b0;
            end else begin
                if (push && head_q == IDX_W'(g))
                    ptr_r <= push_ptr;
                if (complete && cur_q == IDX_W'(g))
                    ab_r <= complete_aborted;
            end
        end
        assign ptr_all[g] = ptr_r;
        assign ab_all[g]  = ab_r;
    end

    assign pop = rel_valid && rel_ready;

    // Index, free, pending and done bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cur_q  <= '0;
            serv_q <= '0;
            free_q <= FREE_INIT;
            pend_q <= '0;
            done_q <= '0;
        end else begin
            if (push)     head_q <= step_idx(head_q);
            if (complete) begin
                cur_q  <= step_idx(cur_q);
                done_q <= done_q + 1'b1;
            end
            if (pop)      serv_q <= step_idx(serv_q);
            case ({push, pop})
                2'b10:   free_q <= free_q - 1'b1;
                2'b01:   free_q <= free_q + 1'b1;
                default: free_q <= free_q;
            endcase
            case ({push, fire_pop})
                2'b10:   pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign free_count   = free_q;
    assign cur_ptr      = ptr_all[cur_q];
    assign work_pending = (pend_q != '0);
    assign rel_valid    = (serv_q != cur_q);
    assign rel_slot     = serv_q;
    assign rel_aborted  = ab_all[serv_q];
    assign done_count   = done_q;

    // R2
    free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_q <= FREE_INIT);
    // R2
    push_takes_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (free_q == $past(free_q) - 1'b1));
    // R4
    complete_has_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |-> (cur_q != head_q));
    // R8
    rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !rel_ready) |=> (rel_valid && $stable(rel_slot)));
    // R10
    fire_has_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_pop |-> (pend_q != '0));
endmodule

// File: rtl/dbs_deadline.sv
// Transfer deadline counter: loaded on arm, counts down while run is high,
// and flags expiry when it reaches zero during a run.
// Assumes TIMEOUT >= 2.
module dbs_deadline #(
    parameter int TIMEOUT = 1000,
    localparam int TW     = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    output logic expired
);
    localparam logic [TW-1:0] RELOAD = TW'(TIMEOUT - 1);

    logic [TW-1:0] cnt_q;

    // Reload on arm, otherwise count down toward zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= RELOAD;
        else if (arm)
            cnt_q <= RELOAD;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/dbs_engine_seq.sv
// Engine sequencer: issues the start sequence, detects completion
// (done flag, or an abort followed by the enable status dropping),
// issues abort writes on deadline expiry and the engine-off write when idle.
// Assumes one register write per cycle and that the engine samples each write.
module dbs_engine_seq
    import dbs_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             work_pending,
    input  logic [PTR_W-1:0] cur_ptr,
    input  logic             eng_done,
    input  logic             eng_enable,
    input  logic             expired,
    output logic             reg_wr_en,
    output logic [2:0]       reg_wr_sel,
    output logic [PTR_W-1:0] reg_wr_data,
    output logic             fire_pop,
    output logic             complete,
    output logic             complete_aborted,
    output logic             arm,
    output logic             run
);
    localparam logic [2:0] LAST_STEP = 3'd6;

    seq_state_e state_q, state_d;
    logic [2:0] step_q, step_d;
    logic       abort_q, abort_d;
    logic       on_q, on_d;
    eng_reg_e   sel;
    logic       finish;

    function automatic logic [PTR_W-1:0] bitv(input int b);
        logic [PTR_W-1:0] v;
        v    = '0;
        v[b] = 1'b1;
        return v;
    endfunction

    // Start-sequence write for a given step.
    function automatic void fire_write(input logic [2:0] s, input logic [PTR_W-1:0] p,
                                       output eng_reg_e rs, output logic [PTR_W-1:0] rd);
        case (s)
            3'd0:    begin rs = SEL_MEM_ADDR; rd = '0; end
            3'd1:    begin rs = SEL_DEV_ADDR; rd = '0; end
            3'd2:    begin rs = SEL_CTRL;
                           rd = bitv(CTRL_DONE) | bitv(CTRL_DDONE) | bitv(CTRL_EN); end
            3'd3:    begin rs = SEL_MODE; rd = bitv(MODE_CHAIN) | bitv(MODE_IRQ); end
            3'd4:    begin rs = SEL_COUNT; rd = '0; end
            3'd5:    begin rs = SEL_DESC; rd = p; end
            default: begin rs = SEL_CTRL; rd = bitv(CTRL_EN) | bitv(CTRL_START); end
        endcase
    endfunction

    assign run    = (state_q == ST_ACTIVE);
    assign finish = eng_done || (abort_q && !eng_enable);

    // Next-state, write and event decode for the sequencer.
    always_comb begin
        state_d          = state_q;
        step_d           = step_q;
        abort_d          = abort_q;
        on_d             = on_q;
        reg_wr_en        = 1'b0;
        sel              = SEL_MEM_ADDR;
        reg_wr_data      = '0;
        fire_pop         = 1'b0;
        complete         = 1'b0;
        complete_aborted = 1'b0;
        arm              = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (work_pending) begin
                    reg_wr_en = 1'b1;
                    fire_write(3'd0, cur_ptr, sel, reg_wr_data);
                    step_d  = 3'd1;
                    state_d = ST_FIRE;
                end else if (on_q) begin
                    reg_wr_en   = 1'b1;
                    sel         = SEL_CTRL;
                    reg_wr_data = bitv(CTRL_DONE) | bitv(CTRL_DDONE);
                    on_d        = 1'b0;
                end
            end
            ST_FIRE: begin
                reg_wr_en = 1'b1;
                fire_write(step_q, cur_ptr, sel, reg_wr_data);
                if (step_q == LAST_STEP) begin
                    fire_pop = 1'b1;
                    arm      = 1'b1;
                    on_d     = 1'b1;
                    state_d  = ST_ACTIVE;
                end else begin
                    step_d = step_q + 1'b1;
                end
            end
            default: begin
                if (finish) begin
                    reg_wr_en        = 1'b1;
                    sel              = SEL_CTRL;
                    reg_wr_data      = bitv(CTRL_DONE);
                    complete         = 1'b1;
                    complete_aborted = abort_q;
                    abort_d          = 1'b0;
                    state_d          = ST_IDLE;
                end else if (expired) begin
                    reg_wr_en   = 1'b1;
                    sel         = SEL_CTRL;
                    reg_wr_data = bitv(CTRL_ABORT);
                    abort_d     = 1'b1;
                    arm         = 1'b1;
                end
            end
        endcase
    end

    assign reg_wr_sel = sel;

    // Sequencer state registers; the engine is assumed on after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            abort_q <= 1'b0;
            on_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            abort_q <= abort_d;
            on_q    <= on_d;
        end
    end

    // R3
    start_after_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_sel == SEL_CTRL && reg_wr_data[CTRL_START])
        |-> $past(reg_wr_en && reg_wr_sel == SEL_DESC));
    // R5
    abort_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_sel == SEL_CTRL && reg_wr_data[CTRL_ABORT])
        |-> $past(run));
    // R9
    complete_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |-> $past(fire_pop || run));
endmodule

// File: rtl/dma_blit_sched.sv
// Top of the DMA slot scheduler: joins the slot ring, the engine sequencer
// and the deadline counter.
// Assumes PTR_W >= 5 so that every control bit fits in the write data.
module dma_blit_sched #(
    parameter int SLOTS   = 4,
    parameter int PTR_W   = 32,
    parameter int TIMEOUT = 125_000_000,
    parameter int DONE_W  = 16,
    localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW     = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              submit_valid,
    input  logic [PTR_W-1:0]  submit_ptr,
    output logic              submit_ready,
    output logic [CW-1:0]     free_count,
    output logic              reg_wr_en,
    output logic [2:0]        reg_wr_sel,
    output logic [PTR_W-1:0]  reg_wr_data,
    input  logic              eng_done,
    input  logic              eng_enable,
    output logic              rel_valid,
    input  logic              rel_ready,
    output logic [IDX_W-1:0]  rel_slot,
    output logic              rel_aborted,
    output logic [DONE_W-1:0] done_count
);
    logic             push, fire_pop, complete, complete_aborted;
    logic             work_pending, arm, run, expired;
    logic [PTR_W-1:0] cur_ptr;

    assign submit_ready = (free_count != '0);
    assign push         = submit_valid && submit_ready;

    dbs_ring #(.SLOTS(SLOTS), .PTR_W(PTR_W), .DONE_W(DONE_W)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_ptr(submit_ptr),
        .fire_pop(fire_pop), .complete(complete), .complete_aborted(complete_aborted),
        .rel_ready(rel_ready), .free_count(free_count), .cur_ptr(cur_ptr),
        .work_pending(work_pending), .rel_valid(rel_valid), .rel_slot(rel_slot),
        .rel_aborted(rel_aborted), .done_count(done_count)
    );

    dbs_engine_seq #(.PTR_W(PTR_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .work_pending(work_pending), .cur_ptr(cur_ptr),
        .eng_done(eng_done), .eng_enable(eng_enable), .expired(expired),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .fire_pop(fire_pop), .complete(complete), .complete_aborted(complete_aborted),
        .arm(arm), .run(run)
    );

    dbs_deadline #(.TIMEOUT(TIMEOUT)) u_deadline (
        .clk(clk), .rst_n(rst_n), .arm(arm), .run(run), .expired(expired)
    );
endmodule

// File: tb/tb_dma_blit_sched.sv
module tb_dma_blit_sched;
    localparam int SLOTS = 4;
    localparam int PTR_W = 32;
    localparam int TMO   = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        submit_valid = 1'b0;
    logic [31:0] submit_ptr = '0;
    logic        submit_ready;
    logic [2:0]  free_count;
    logic        reg_wr_en;
    logic [2:0]  reg_wr_sel;
    logic [31:0] reg_wr_data;
    logic        eng_done = 1'b0;
    logic        eng_enable = 1'b1;
    logic        rel_valid;
    logic        rel_ready = 1'b0;
    logic [1:0]  rel_slot;
    logic        rel_aborted;
    logic [15:0] done_count;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wn     = 0;
    int rn     = 0;
    int lsel [256];
    int ldat [256];
    int lcyc [256];
    int last_cyc;

    always #4 clk = ~clk;

    dma_blit_sched #(.SLOTS(SLOTS), .PTR_W(PTR_W), .TIMEOUT(TMO), .DONE_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .submit_valid(submit_valid), .submit_ptr(submit_ptr),
        .submit_ready(submit_ready), .free_count(free_count), .reg_wr_en(reg_wr_en),
        .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data), .eng_done(eng_done),
        .eng_enable(eng_enable), .rel_valid(rel_valid), .rel_ready(rel_ready),
        .rel_slot(rel_slot), .rel_aborted(rel_aborted), .done_count(done_count)
    );

    // Log every engine register write, sampled mid-cycle.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && reg_wr_en) begin
            lsel[wn % 256] = int'(reg_wr_sel);
            ldat[wn % 256] = int'(reg_wr_data);
            lcyc[wn % 256] = cyc;
            wn = wn + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic mid();
        @(negedge clk);
        #1;
    endtask

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_write(input int sel, input int dat, input string tag);
        int n = 0;
        while (wn == rn && n < 100) begin
            mid();
            n++;
        end
        if (wn == rn) begin
            chk(1'b0, {tag, " no write"}, 0, dat);
        end else begin
            chk(lsel[rn % 256] == sel && ldat[rn % 256] == dat, tag,
                (lsel[rn % 256] << 28) | ldat[rn % 256], (sel << 28) | dat);
            last_cyc = lcyc[rn % 256];
            rn++;
        end
    endtask

    task automatic expect_start(input int ptr, input string tag);
        expect_write(0, 0, tag);
        expect_write(1, 0, tag);
        expect_write(2, 32'h19, tag);
        expect_write(3, 32'h3, tag);
        expect_write(4, 0, tag);
        expect_write(5, ptr, tag);
        expect_write(2, 32'h3, tag);
    endtask

    task automatic submit(input int ptr);
        submit_ptr   = ptr;
        submit_valid = 1'b1;
        edge1();
        submit_valid = 1'b0;
    endtask

    task automatic pulse_done();
        edge1();
        eng_done = 1'b1;
        edge1();
        eng_done = 1'b0;
    endtask

    task automatic do_release(input int slot, input bit ab, input string tag);
        int n = 0;
        int fc;
        mid();
        while (!rel_valid && n < 50) begin
            mid();
            n++;
        end
        chk(rel_valid && int'(rel_slot) == slot, {tag, " slot"}, int'(rel_slot), slot);
        chk(rel_aborted == ab, {tag, " aborted"}, int'(rel_aborted), int'(ab));
        fc = int'(free_count);
        edge1();
        rel_ready = 1'b1;
        edge1();
        rel_ready = 1'b0;
        mid();
        chk(int'(free_count) == fc + 1, {tag, " free up"}, int'(free_count), fc + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int t0;
        repeat (3) edge1();
        rst_n = 1'b1;
        mid();
        // R1 reset state
        chk(free_count == 3'd3, "R1 free", int'(free_count), 3);
        chk(submit_ready && !rel_valid, "R1 ready/rel", int'({submit_ready, rel_valid}), 2);
        chk(done_count == 16'd0, "R1 done_count", int'(done_count), 0);
        // R7 single off write after reset
        expect_write(2, 32'h18, "R7 off after reset");
        repeat (5) mid();
        chk(wn == rn, "R7 off only once", wn - rn, 0);

        // R9 done pulse while idle is ignored
        edge1();
        eng_done = 1'b1;
        repeat (3) edge1();
        eng_done = 1'b0;
        mid();
        chk(wn == rn, "R9 no write when idle", wn - rn, 0);
        chk(done_count == 16'd0, "R9 done_count idle", int'(done_count), 0);

        // R3/R4 single transfer through the done flag
        submit(32'h1000);
        mid();
        chk(free_count == 3'd2, "R2 free after submit", int'(free_count), 2);
        expect_start(32'h1000, "R3 start 0x1000");
        pulse_done();
        expect_write(2, 32'h10, "R4 clear done");
        expect_write(2, 32'h18, "R7 off after done");
        chk(done_count == 16'd1, "R4 done_count", int'(done_count), 1);
        do_release(0, 1'b0, "R4 release");

        // R2/R8/R10 fill the ring, then refuse
        submit(32'h2000);
        submit(32'h3000);
        submit(32'h4000);
        mid();
        chk(free_count == 3'd0 && !submit_ready, "R2 full", int'(free_count), 0);
        edge1();
        submit(32'h9999);
        mid();
        chk(free_count == 3'd0, "R2 refused keeps free", int'(free_count), 0);
        expect_start(32'h2000, "R3 fifo 0x2000");
        pulse_done();
        expect_write(2, 32'h10, "R4 clear 2");
        expect_start(32'h3000, "R3 fifo 0x3000");
        pulse_done();
        expect_write(2, 32'h10, "R4 clear 3");
        expect_start(32'h4000, "R3 fifo 0x4000");
        pulse_done();
        expect_write(2, 32'h10, "R4 clear 4");
        expect_write(2, 32'h18, "R7 off after burst");
        chk(done_count == 16'd4, "R4 done_count burst", int'(done_count), 4);
        do_release(1, 1'b0, "R8 release 1");
        do_release(2, 1'b0, "R8 release 2");
        do_release(3, 1'b0, "R8 release 3");
        mid();
        chk(free_count == 3'd3, "R8 free restored", int'(free_count), 3);

        // R5/R6/R10 stalled transfer, wrapped to slot 0
        submit(32'h5000);
        expect_start(32'h5000, "R10 wrap start");
        t0 = last_cyc;
        expect_write(2, 32'h04, "R5 abort");
        chk(last_cyc - t0 == TMO, "R5 abort timing", last_cyc - t0, TMO);
        t0 = last_cyc;
        expect_write(2, 32'h04, "R6 rearm abort");
        chk(last_cyc - t0 == TMO, "R5 rearm timing", last_cyc - t0, TMO);
        chk(done_count == 16'd4, "R6 no completion while enabled", int'(done_count), 4);
        edge1();
        eng_enable = 1'b0;
        expect_write(2, 32'h10, "R6 abort completes");
        expect_write(2, 32'h18, "R7 off after abort");
        eng_enable = 1'b1;
        chk(done_count == 16'd5, "R6 done_count", int'(done_count), 5);
        do_release(0, 1'b1, "R6 release aborted R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule